// File: doc/BRIEF.md
# External Bank Strobe Timing Sequencer

This block runs one access at a time on an external bus shared by ROM, SRAM and slow peripherals. It has five banks, and each bank has its own 32-bit timing word. The word sets four things: how long the access lasts, how many cycles after the address appears the chip select goes low, and how many cycles after the chip select the output enable or the write enable go low. A requester presents a bank number, a read/write flag, an address and write data. The sequencer drives the address, a write-data drive enable and the active-low strobes. It captures read data near the end of the access and signals completion with a one-cycle pulse.

A device can stretch any access through a ready input. Each bank word chooses whether ready is ignored, used as a synchronous signal, or taken through a synchronizer as an asynchronous signal. The timing word is copied when an access starts. A host can therefore rewrite any bank word at any time, and the change applies from the next access onward.

Top module: `xbus_timing_seq`

## Requirements
- R1: Five timing words sit at configuration offsets 0xE0, 0xE4, 0xE8, 0xEC and 0xF0 (bank 0 to 4). Each resets to 0xFC03F8F0. Any other offset reads 0 and ignores writes.
- R2: All 32 bits of a timing word are writable and read back. Fields are numbered with bit 31 as the most significant: wait count N in [31:26], chip-select delay C in [25:24], output-enable delay E in [23:22], write-enable delay W in [21:20], ready enable in [19] and ready-asynchronous select in [18].
- R3: Number the cycles of an access 0, 1, 2 and so on, starting with the first cycle in which addr_vld is high, one cycle after acceptance. addr_vld is high and mem_addr holds the request address from cycle 0 through cycle N. When ready is not in use, the access ends there. cs_n is low from cycle C until the access ends.
- R4: On a read, oe_n is low from cycle C+E until the access ends. On a write, oe_n stays high.
- R5: On a write, we_n is low from cycle C+W until the access ends. On a read, we_n stays high.
- R6: On a write, dq_oe is high and mem_dout holds the write data from cycle C+E until the access ends.
- R7: All strobes are high when no access is running. A strobe whose start cycle is later than N never asserts during that access.
- R8: With ready enabled and in synchronous mode, the access holds in cycle N while ext_ready is low at the clock edge. It ends in the first cycle at whose closing edge ext_ready is high.
- R9: In asynchronous mode, ext_ready passes through two flip-flops before it is used, so a rise in cycle k releases the hold at the end of cycle k+2 at the earliest.
- R10: In the cycle after the last access cycle, done is high for exactly one cycle. For reads, rd_data then shows mem_din as sampled at the end of the last access cycle.
- R11: The timing word is captured when a request is accepted. A configuration write during an access does not change that access. It applies from the next access.
- R12: req_ready is high exactly when no access is running, and a request is accepted only then. A request naming a bank number of 5 or above is dropped and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_bank | input | 3 | Bank number of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Access address |
| req_wdata | input | 32 | Write data |
| ext_ready | input | 1 | Device ready |
| mem_din | input | 32 | Read data from the external bus |
| mem_addr | output | 24 | External address |
| addr_vld | output | 1 | Address valid, access running |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| dq_oe | output | 1 | Drive write data onto the bus |
| mem_dout | output | 32 | Write data to the external bus |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Captured read data |

## Verification
Every strobe is a compare of the running cycle count against a captured offset. A wrong count or a wrong captured word therefore shows at the ports in the same cycle as a strobe edge one cycle early or late. The same fault also changes the access length and moves the done pulse. A wrong ready path shows as an access that ends too soon or hangs in its last cycle. The reference model flags that at the first cycle of the difference. A bad read capture stays hidden until the done cycle, when rd_data is compared.

// File: rtl/xbus_timing_pkg.sv
package xbus_timing_pkg;

   localparam int WORD_W = 32;
   localparam int TIM_W  = 14;   // used field bits at the top of each word
   localparam logic [WORD_W-1:0] WORD_RESET = 32'hFC03_F8F0;

   typedef struct packed {
      logic [5:0] wait_cnt;   // access length minus one
      logic [1:0] cs_dly;     // address valid -> chip select
      logic [1:0] oe_dly;     // chip select -> output enable / data drive
      logic [1:0] we_dly;     // chip select -> write enable
      logic       rdy_en;     // device ready in use
      logic       rdy_async;  // ready taken through synchronizer
   } bank_tim_t;

   function automatic bank_tim_t to_tim(input logic [TIM_W-1:0] bits);
      return bank_tim_t'(bits);
   endfunction

endpackage

// File: rtl/xbus_bank_regs.sv
module xbus_bank_regs #(
   parameter int                NUM_BANKS = 5,
   parameter int                CFG_AW    = 8,
   parameter logic [CFG_AW-1:0] BASE_OFF  = 8'hE0
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic                                             wr_en,
   input  logic [CFG_AW-1:0]                                addr,
   input  logic [xbus_timing_pkg::WORD_W-1:0]               wdata,
   output logic [xbus_timing_pkg::WORD_W-1:0]               rdata,
   output logic [NUM_BANKS-1:0][xbus_timing_pkg::WORD_W-1:0] words
);
   import xbus_timing_pkg::*;

   localparam int STRIDE = 4;

   if (BASE_OFF[1:0] != 2'b00) begin : g_bad_align
      $error("bank register base must be word aligned");
   end
   if (int'(BASE_OFF) + STRIDE*NUM_BANKS > (1 << CFG_AW)) begin : g_bad_span
      $error("bank registers exceed configuration address space");
   end

   logic [NUM_BANKS-1:0] hit;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign hit[b] = (addr == BASE_OFF + CFG_AW'(STRIDE*b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[b] <= WORD_RESET;
         else if (wr_en && hit[b])
            words[b] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (hit[b]) rdata = words[b];
   end

endmodule

// File: rtl/xbus_ready_sync.sv
module xbus_ready_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_in,
   output logic rdy_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ready synchronizer needs at least two stages");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= 1'b0;
         else if (s == 0)
            chain[s] <= rdy_in;
         else
            chain[s] <= chain[(s > 0) ? s-1 : 0];
      end
   end

   assign rdy_out = chain[STAGES-1];

endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq #(
   parameter int AW = 24,
   parameter int DW = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   input  logic                             start_write,
   input  logic [AW-1:0]                    start_addr,
   input  logic [DW-1:0]                    start_wdata,
   input  xbus_timing_pkg::bank_tim_t       tim,
   input  logic                             rdy_raw,
   input  logic                             rdy_synced,
   input  logic [DW-1:0]                    mem_din,
   output logic                             busy,
   output logic                             done,
   output logic [AW-1:0]                    mem_addr,
   output logic                             cs_n,
   output logic                             oe_n,
   output logic                             we_n,
   output logic                             dq_oe,
   output logic [DW-1:0]                    mem_dout,
   output logic [DW-1:0]                    rd_data
);
   import xbus_timing_pkg::*;

   localparam int CNT_W = $bits(tim.wait_cnt);
   localparam int CMP_W = CNT_W + 1;

   bank_tim_t        snap;
   logic             wr_q;
   logic [CNT_W-1:0] cnt;
   logic             last_cyc;
   logic             go;
   logic [CMP_W-1:0] cnt_x, cs_at, oe_at, we_at;

   assign last_cyc = (cnt == snap.wait_cnt);
   assign go       = !snap.rdy_en || (snap.rdy_async ? rdy_synced : rdy_raw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         cnt      <= '0;
         snap     <= to_tim(WORD_RESET[WORD_W-1 -: TIM_W]);
         wr_q     <= 1'b0;
         mem_addr <= '0;
         mem_dout <= '0;
         rd_data  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy     <= 1'b1;
               cnt      <= '0;
               snap     <= tim;
               wr_q     <= start_write;
               mem_addr <= start_addr;
               mem_dout <= start_wdata;
            end
         end else if (last_cyc) begin
            if (go) begin
               busy <= 1'b0;
               done <= 1'b1;
               if (!wr_q) rd_data <= mem_din;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign cnt_x = {1'b0, cnt};
   assign cs_at = CMP_W'(snap.cs_dly);
   assign oe_at = CMP_W'(snap.cs_dly) + CMP_W'(snap.oe_dly);
   assign we_at = CMP_W'(snap.cs_dly) + CMP_W'(snap.we_dly);

   assign cs_n  = !(busy && cnt_x >= cs_at);
   assign oe_n  = !(busy && !wr_q && cnt_x >= oe_at);
   assign we_n  = !(busy && wr_q && cnt_x >= we_at);
   assign dq_oe =  busy && wr_q && cnt_x >= oe_at;

endmodule

// File: rtl/xbus_timing_seq.sv
module xbus_timing_seq #(
   parameter int                NUM_BANKS   = 5,
   parameter int                CFG_AW      = 8,
   parameter logic [CFG_AW-1:0] CFG_BASE    = 8'hE0,
   parameter int                MEM_AW      = 24,
   parameter int                MEM_DW      = 32,
   parameter int                SYNC_STAGES = 2,
   localparam int               BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BANK_W-1:0] req_bank,
   input  logic              req_write,
   input  logic [MEM_AW-1:0] req_addr,
   input  logic [MEM_DW-1:0] req_wdata,
   input  logic              ext_ready,
   input  logic [MEM_DW-1:0] mem_din,
   output logic [MEM_AW-1:0] mem_addr,
   output logic              addr_vld,
   output logic              cs_n,
   output logic              oe_n,
   output logic              we_n,
   output logic              dq_oe,
   output logic [MEM_DW-1:0] mem_dout,
   output logic              done,
   output logic [MEM_DW-1:0] rd_data
);
   import xbus_timing_pkg::*;

   if (NUM_BANKS < 1 || NUM_BANKS > (1 << BANK_W)) begin : g_bad_banks
      $error("bank count out of range");
   end

   logic [NUM_BANKS-1:0][WORD_W-1:0] words;
   bank_tim_t tim_sel;
   logic      bank_ok;
   logic      busy;
   logic      rdy_synced;

   xbus_bank_regs #(
      .NUM_BANKS(NUM_BANKS), .CFG_AW(CFG_AW), .BASE_OFF(CFG_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .words(words)
   );

   xbus_ready_sync #(.STAGES(SYNC_STAGES)) u_rdy (
      .clk(clk), .rst_n(rst_n), .rdy_in(ext_ready), .rdy_out(rdy_synced)
   );

   always_comb begin
      tim_sel = to_tim(WORD_RESET[WORD_W-1 -: TIM_W]);
      bank_ok = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (req_bank == BANK_W'(b)) begin
            tim_sel = to_tim(words[b][WORD_W-1 -: TIM_W]);
            bank_ok = 1'b1;
         end
      end
   end

   xbus_strobe_seq #(.AW(MEM_AW), .DW(MEM_DW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(req_valid && bank_ok), .start_write(req_write),
      .start_addr(req_addr), .start_wdata(req_wdata), .tim(tim_sel),
      .rdy_raw(ext_ready), .rdy_synced(rdy_synced), .mem_din(mem_din),
      .busy(busy), .done(done), .mem_addr(mem_addr),
      .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .dq_oe(dq_oe),
      .mem_dout(mem_dout), .rd_data(rd_data)
   );

   assign req_ready = !busy;
   assign addr_vld  = busy;

endmodule

// File: rtl/xbus_timing_seq_chk.sv
module xbus_timing_seq_chk #(
   parameter int AW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          addr_vld,
   input logic [AW-1:0] mem_addr,
   input logic          cs_n,
   input logic          oe_n,
   input logic          we_n,
   input logic          dq_oe,
   input logic          done
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cs_n && oe_n && we_n && !dq_oe)); // R7
   AST_READY_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready != addr_vld); // R12
   AST_OE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !cs_n); // R4
   AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !cs_n); // R5
   AST_OE_WE_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n)); // R4
   AST_DRIVE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> oe_n); // R6
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && $past(addr_vld)) |-> $stable(mem_addr)); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(addr_vld) && !addr_vld)); // R10
endmodule

bind xbus_timing_seq xbus_timing_seq_chk #(.AW(MEM_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .addr_vld(addr_vld),
   .mem_addr(mem_addr), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
   .dq_oe(dq_oe), .done(done)
);

// File: tb/xbus_timing_seq_test.sv
`timescale 1ns/1ps
module xbus_timing_seq_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_wr = 0;
   logic [7:0]  cfg_addr = 0;
   logic [31:0] cfg_wdata = 0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 0;
   logic        req_ready;
   logic [2:0]  req_bank = 0;
   logic        req_write = 0;
   logic [23:0] req_addr = 0;
   logic [31:0] req_wdata = 0;
   logic        ext_ready = 0;
   logic [31:0] mem_din = 32'h1357_9BDF;
   logic [23:0] mem_addr;
   logic        addr_vld, cs_n, oe_n, we_n, dq_oe, done;
   logic [31:0] mem_dout, rd_data;

   int vectors = 0;
   int fails = 0;

   always #5 clk = ~clk;

   xbus_timing_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_bank(req_bank), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .ext_ready(ext_ready),
      .mem_din(mem_din), .mem_addr(mem_addr), .addr_vld(addr_vld),
      .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .dq_oe(dq_oe),
      .mem_dout(mem_dout), .done(done), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] mk(input int n, input int c, input int e,
                                      input int w, input bit ren, input bit ras);
      return {n[5:0], c[1:0], e[1:0], w[1:0], ren, ras, 18'h0};
   endfunction

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_regs [5];
   bit  m_busy, m_done, m_wr, m_ren, m_ras, r1, r2;
   int  m_idx, m_n, m_c, m_e, m_w;
   logic [23:0] m_addr;
   logic [31:0] m_wd, m_rd;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_regs[i]) m_regs[i] = 32'hFC03_F8F0;
         m_busy = 0; m_done = 0; m_idx = 0; r1 = 0; r2 = 0; m_rd = 0;
      end else begin
         bit go;
         go = !m_ren || (m_ras ? r2 : ext_ready);
         m_done = 0;
         if (m_busy) begin
            if (m_idx == m_n) begin
               if (go) begin
                  m_busy = 0; m_done = 1;
                  if (!m_wr) m_rd = mem_din;
               end
            end else m_idx++;
         end else if (req_valid && req_bank < 5) begin
            logic [31:0] wv;
            wv = m_regs[req_bank];
            m_n = wv[31:26]; m_c = wv[25:24]; m_e = wv[23:22]; m_w = wv[21:20];
            m_ren = wv[19]; m_ras = wv[18];
            m_wr = req_write; m_addr = req_addr; m_wd = req_wdata;
            m_busy = 1; m_idx = 0;
         end
         r2 = r1; r1 = ext_ready;
         if (cfg_wr && cfg_addr >= 8'hE0 && cfg_addr <= 8'hF0 && cfg_addr[1:0] == 0)
            m_regs[(cfg_addr - 8'hE0) >> 2] = cfg_wdata;
      end
   end

   always @(negedge clk) begin
      mem_din <= mem_din * 32'd1103515245 + 32'd12345;
      if (rst_n) begin
         chk("R3 addr_vld", addr_vld, m_busy);
         chk("R3 cs_n", cs_n, !(m_busy && m_idx >= m_c));
         chk("R4 oe_n", oe_n, !(m_busy && !m_wr && m_idx >= m_c + m_e));
         chk("R5 we_n", we_n, !(m_busy && m_wr && m_idx >= m_c + m_w));
         chk("R6 dq_oe", dq_oe, m_busy && m_wr && m_idx >= m_c + m_e);
         chk("R10 done", done, m_done);
         chk("R10 rd_data", rd_data, m_rd);
         chk("R12 req_ready", req_ready, !m_busy);
         if (m_busy) chk("R3 mem_addr", mem_addr, m_addr);
         if (m_busy && m_wr && m_idx >= m_c + m_e) chk("R6 mem_dout", mem_dout, m_wd);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic cfg_write(input logic [7:0] off, input logic [31:0] val);
      @(negedge clk); cfg_wr = 1; cfg_addr = off; cfg_wdata = val;
      @(negedge clk); cfg_wr = 0;
   endtask

   task automatic cfg_check(input string tag, input logic [7:0] off, input logic [31:0] exp);
      @(negedge clk); cfg_addr = off; #1;
      chk(tag, cfg_rdata, exp);
   endtask

   task automatic access(input int bank, input bit wr, input logic [23:0] a,
                         input logic [31:0] d, input int raise_at,
                         input int mid_at, input logic [7:0] mid_off,
                         input logic [31:0] mid_val,
                         output int len, output int csl, output int oel,
                         output int wel, output int dql);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_bank = bank[2:0]; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0;
      len = 0; csl = 0; oel = 0; wel = 0; dql = 0;
      for (int i = 0; i < 400; i++) begin
         cfg_wr = 0;
         if (done) break;
         if (addr_vld) begin
            if (!cs_n) csl++;
            if (!oe_n) oel++;
            if (!we_n) wel++;
            if (dq_oe) dql++;
            if (len == raise_at) ext_ready = 1;
            if (len == mid_at) begin cfg_wr = 1; cfg_addr = mid_off; cfg_wdata = mid_val; end
            len++;
         end
         @(negedge clk);
      end
      cfg_wr = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int len, csl, oel, wel, dql;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R12 reset req_ready", req_ready, 1);
      chk("R7 reset cs_n", cs_n, 1);
      for (int b = 0; b < 5; b++) cfg_check("R1 reset word", 8'hE0 + 8'(4*b), 32'hFC03_F8F0);
      cfg_check("R1 unmapped offset", 8'hF4, 0);
      cfg_write(8'hF4, 32'hDEAD_BEEF);
      cfg_check("R1 unmapped write ignored", 8'hF4, 0);

      // default timing: N=63, all delays 0, read
      access(0, 0, 24'h00_1000, 0, -1, -1, 0, 0, len, csl, oel, wel, dql);
      chk("R3 default length", len, 64);
      chk("R3 default cs low", csl, 64);
      chk("R4 default oe low", oel, 64);

      // read with delays
      cfg_write(8'hE4, mk(5, 1, 2, 0, 0, 0) | 32'h0002_A5A5);
      cfg_check("R2 readback all bits", 8'hE4, mk(5, 1, 2, 0, 0, 0) | 32'h0002_A5A5);
      access(1, 0, 24'hABCDEF, 0, -1, -1, 0, 0, len, csl, oel, wel, dql);
      chk("R3 length N+1", len, 6);
      chk("R3 cs from C", csl, 5);
      chk("R4 oe from C+E", oel, 3);
      chk("R5 no we on read", wel, 0);

      // write with delays
      cfg_write(8'hE8, mk(4, 2, 1, 2, 0, 0));
      access(2, 1, 24'h00_0042, 32'hCAFE_F00D, -1, -1, 0, 0, len, csl, oel, wel, dql);
      chk("R3 write length", len, 5);
      chk("R3 write cs", csl, 3);
      chk("R5 we from C+W", wel, 1);
      chk("R6 dq from C+E", dql, 2);
      chk("R4 no oe on write", oel, 0);
      access(2, 1, 24'h00_0043, 32'h0BAD_F00D, -1, -1, 0, 0, len, csl, oel, wel, dql);
      chk("R6 back-to-back write dq", dql, 2);

      // strobe later than end never asserts
      cfg_write(8'hEC, mk(1, 3, 0, 0, 0, 0));
      access(3, 0, 24'h000007, 0, -1, -1, 0, 0, len, csl, oel, wel, dql);
      chk("R7 length", len, 2);
      chk("R7 cs never", csl, 0);
      chk("R7 oe never", oel, 0);

      // synchronous ready hold
      ext_ready = 0;
      cfg_write(8'hF0, mk(2, 0, 0, 0, 1, 0));
      access(4, 0, 24'h000100, 0, 6, -1, 0, 0, len, csl, oel, wel, dql);
      chk("R8 sync hold length", len, 7);
      chk("R8 cs held", csl, 7);

      // asynchronous ready: two more cycles
      ext_ready = 0;
      cfg_write(8'hF0, mk(2, 0, 0, 0, 1, 1));
      repeat (3) @(negedge clk);
      access(4, 1, 24'h000200, 32'h1111_2222, 6, -1, 0, 0, len, csl, oel, wel, dql);
      chk("R9 async hold length", len, 9);
      repeat (3) @(negedge clk);
      access(4, 0, 24'h000201, 0, -1, -1, 0, 0, len, csl, oel, wel, dql);
      chk("R9 async ready already high", len, 3);

      // word captured at start
      cfg_write(8'hE4, mk(4, 0, 0, 0, 0, 0));
      access(1, 0, 24'h000300, 0, -1, 1, 8'hE4, mk(1, 0, 0, 0, 0, 0), len, csl, oel, wel, dql);
      chk("R11 running access unchanged", len, 5);
      access(1, 0, 24'h000301, 0, -1, -1, 0, 0, len, csl, oel, wel, dql);
      chk("R11 next access uses new word", len, 2);
      cfg_check("R11 new word readback", 8'hE4, mk(1, 0, 0, 0, 0, 0));

      // bank out of range
      @(negedge clk);
      req_valid = 1; req_bank = 3'd5; req_write = 0;
      @(negedge clk);
      req_valid = 0; req_bank = 3'd7; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      chk("R12 bad bank dropped", addr_vld, 0);
      @(negedge clk);
      chk("R12 bad bank dropped later", addr_vld, 0);
      chk("R12 still idle", req_ready, 1);

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule